// File: doc/BRIEF.md
# Operate-Class Micro-Operation Executor

This block carries out the register-only "operate" instructions of an 18-bit ones'-complement processor. The surrounding core presents a fetched instruction word together with the current accumulator (AC), IO register, program counter, program flags and the console test word. When the word belongs to the operate class, every micro-operation selected by its low twelve bits is applied in one clock. The new AC, IO and flags are registered, and a one-cycle halt strobe is raised when requested. Words carrying one of the reserved (spare) major opcodes also halt the machine and change no register.

Micro-operations that are OR-ed into one word run in a fixed internal order. Both clears act first. The test word and the program counter are then OR-ed in, and the AC complement acts last. One 3-bit field names a single flag, all six flags, or none, and a companion bit chooses whether the selected flags are set or cleared. Once a halt is taken the block ignores further instructions and holds its outputs until a continue pulse or a reset arrives.

Top module: `opr_exec`

## Requirements
- R1: While reset is asserted (rst_n low), ac_o, io_o and flags_o are zero and halt_o, spare_o and halted_o are low.
- R2: A word is an operate instruction when instr_i[17:13] is 5'b11111 (octal 76 or 77). When valid_i is high and the block is not halted, the results of an operate instruction appear on ac_o, io_o and flags_o after the next rising edge. A word that is neither operate nor spare leaves every output unchanged.
- R3: Bit 7 (octal 000200) clears AC and bit 11 (octal 004000) clears IO. Both clears act before any other micro-operation. A register that is not cleared starts from ac_i or io_i, and IO is changed by nothing else.
- R4: Bit 10 (octal 002000) ORs test_i into AC. Bit 6 (octal 000100) ORs pc_i[11:0] into AC, zero-extended, with pc_i[15:12] discarded. Both act after the clears, so 762200 loads the test word.
- R5: Bit 9 (octal 001000) inverts every AC bit, and it acts after all clears and ORs.
- R6: Bits [2:0] select the flags. A value n from 1 to 6 selects flag n (flags bit n-1), 7 selects all six flags, and 0 selects none. Bit 3 (octal 000010) set means the selected flags are set, and clear means they are cleared. Flags that are not selected keep their flags_i values.
- R7: Bit 8 (octal 000400) raises halt_o for exactly one cycle, in the same edge as the register updates of that word, and sets halted_o.
- R8: A valid word whose instr_i[17:12] is octal 00, 12, 14, 36 or 74 (or the same value with bit 12 set) pulses halt_o and spare_o for one cycle and sets halted_o. AC, IO and flags keep their previous values.
- R9: While halted_o is high, valid instructions are ignored and no strobe is raised. A cont_i pulse clears halted_o at the next edge.
- R10: With valid_i low, ac_o, io_o and flags_o keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Instruction word present this cycle |
| instr_i | input | 18 | Instruction word |
| ac_i | input | 18 | Current accumulator |
| io_i | input | 18 | Current IO register |
| pc_i | input | 16 | Current program counter |
| test_i | input | 18 | Console test word |
| flags_i | input | 6 | Current program flags |
| cont_i | input | 1 | Continue after a halt |
| ac_o | output | 18 | Registered next accumulator |
| io_o | output | 18 | Registered next IO register |
| flags_o | output | 6 | Registered next program flags |
| halt_o | output | 1 | One-cycle halt strobe |
| spare_o | output | 1 | One-cycle strobe for a spare opcode halt |
| halted_o | output | 1 | Halted state, cleared by cont_i |

## Verification
A wrong stage order or a bad field decode shows as a wrong ac_o, io_o or flags_o value on the cycle after the word is presented. Every step of the datapath feeds a register directly, so no error can stay hidden for later cycles. A stuck or missing halted state shows on the next instruction: either the block executes a word it should have ignored, or it ignores one it should have run. A halt strobe that is too long shows on the cycle after the halt.

// File: rtl/opr_pkg.sv
package opr_pkg;

    localparam int WORD_W    = 18;
    localparam int FLAG_N    = 6;
    localparam int PC_W      = 16;
    localparam int PC_ADDR_W = 12;
    localparam int OPC_W     = 5;
    localparam int FSEL_W    = $clog2(FLAG_N + 2);

    // micro-operation bit positions in the low field
    localparam int B_FSET = 3;
    localparam int B_LAP  = 6;
    localparam int B_CLA  = 7;
    localparam int B_HLT  = 8;
    localparam int B_CMA  = 9;
    localparam int B_LAT  = 10;
    localparam int B_CLI  = 11;

    localparam logic [OPC_W-1:0] OPC_OPERATE = 5'b11111;

    localparam int SPARE_N = 5;
    localparam logic [OPC_W-1:0] SPARE_OPC [SPARE_N] =
        '{5'd0, 5'd5, 5'd6, 5'd15, 5'd30};

    typedef struct packed {
        logic              is_opr;
        logic              is_spare;
        logic              clr_ac;
        logic              clr_io;
        logic              or_tw;
        logic              or_pc;
        logic              cma;
        logic              hlt;
        logic              flag_set;
        logic [FSEL_W-1:0] flag_sel;
    } opr_ctl_t;

    typedef struct packed {
        logic [WORD_W-1:0] ac;
        logic [WORD_W-1:0] io;
        logic [FLAG_N-1:0] flags;
        logic              halt;
        logic              spare;
        logic              halted;
    } opr_state_t;

endpackage

// File: rtl/opr_decode.sv
module opr_decode
    import opr_pkg::*;
(
    input  logic [WORD_W-1:0] instr_i,
    output opr_ctl_t          ctl_o
);

    localparam int OPC_LSB = WORD_W - OPC_W;

    logic [OPC_W-1:0]   opc;
    logic [SPARE_N-1:0] spare_hit;
    logic               unused_bits;

    assign opc = instr_i[WORD_W-1 -: OPC_W];

    for (genvar k = 0; k < SPARE_N; k++) begin : g_spare
        assign spare_hit[k] = (opc == SPARE_OPC[k]);
    end

    assign unused_bits = ^{instr_i[OPC_LSB-1 -: 1], instr_i[B_CLA-3 +: 2]};

    always_comb begin
        ctl_o          = '0;
        ctl_o.is_opr   = (opc == OPC_OPERATE);
        ctl_o.is_spare = |spare_hit;
        ctl_o.clr_ac   = instr_i[B_CLA];
        ctl_o.clr_io   = instr_i[B_CLI];
        ctl_o.or_tw    = instr_i[B_LAT];
        ctl_o.or_pc    = instr_i[B_LAP];
        ctl_o.cma      = instr_i[B_CMA];
        ctl_o.hlt      = instr_i[B_HLT];
        ctl_o.flag_set = instr_i[B_FSET];
        ctl_o.flag_sel = instr_i[FSEL_W-1:0];
    end

endmodule

// File: rtl/opr_acio.sv
module opr_acio
    import opr_pkg::*;
(
    input  logic              clr_ac_i,
    input  logic              clr_io_i,
    input  logic              or_tw_i,
    input  logic              or_pc_i,
    input  logic              cma_i,
    input  logic [WORD_W-1:0] ac_i,
    input  logic [WORD_W-1:0] io_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [WORD_W-1:0] test_i,
    output logic [WORD_W-1:0] ac_n_o,
    output logic [WORD_W-1:0] io_n_o
);

    localparam int PAD_W = WORD_W - PC_ADDR_W;

    logic [WORD_W-1:0] pc_ext;
    logic [WORD_W-1:0] ac_clr_d;
    logic [WORD_W-1:0] ac_or_d;
    logic              unused_pc_hi;

    assign pc_ext       = {{PAD_W{1'b0}}, pc_i[PC_ADDR_W-1:0]};
    assign unused_pc_hi = ^pc_i[PC_W-1:PC_ADDR_W];

    always_comb begin
        // stage 1: clears
        ac_clr_d = clr_ac_i ? '0 : ac_i;
        io_n_o   = clr_io_i ? '0 : io_i;
        // stage 2: OR sources
        ac_or_d  = ac_clr_d;
        if (or_tw_i) ac_or_d = ac_or_d | test_i;
        if (or_pc_i) ac_or_d = ac_or_d | pc_ext;
        // stage 3: complement
        ac_n_o   = cma_i ? ~ac_or_d : ac_or_d;
    end

    always_comb begin
        if (cma_i && clr_ac_i && !or_tw_i && !or_pc_i) begin
            AST_CMA_AFTER_CLEAR: assert (ac_n_o == {WORD_W{1'b1}}); // R5
        end
    end

endmodule

// File: rtl/opr_flags.sv
module opr_flags
    import opr_pkg::*;
(
    input  logic              set_i,
    input  logic [FSEL_W-1:0] sel_i,
    input  logic [FLAG_N-1:0] flags_i,
    output logic [FLAG_N-1:0] flags_n_o
);

    localparam logic [FSEL_W-1:0] FSEL_ALL = {FSEL_W{1'b1}};

    logic [FLAG_N-1:0] mask;

    for (genvar k = 0; k < FLAG_N; k++) begin : g_mask
        assign mask[k] = (sel_i == FSEL_ALL) || (sel_i == FSEL_W'(k + 1));
    end

    always_comb begin
        flags_n_o = set_i ? (flags_i | mask) : (flags_i & ~mask);
    end

    always_comb begin
        if (sel_i == '0) begin
            AST_FLAG_NONE: assert (flags_n_o == flags_i); // R6
        end
    end

endmodule

// File: rtl/opr_exec.sv
module opr_exec
    import opr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [WORD_W-1:0] instr_i,
    input  logic [WORD_W-1:0] ac_i,
    input  logic [WORD_W-1:0] io_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [WORD_W-1:0] test_i,
    input  logic [FLAG_N-1:0] flags_i,
    input  logic              cont_i,
    output logic [WORD_W-1:0] ac_o,
    output logic [WORD_W-1:0] io_o,
    output logic [FLAG_N-1:0] flags_o,
    output logic              halt_o,
    output logic              spare_o,
    output logic              halted_o
);

    opr_ctl_t          ctl;
    opr_state_t        st_d;
    opr_state_t        st_q;
    logic [WORD_W-1:0] ac_n;
    logic [WORD_W-1:0] io_n;
    logic [FLAG_N-1:0] flags_n;

    opr_decode u_decode (
        .instr_i (instr_i),
        .ctl_o   (ctl)
    );

    opr_acio u_acio (
        .clr_ac_i (ctl.clr_ac),
        .clr_io_i (ctl.clr_io),
        .or_tw_i  (ctl.or_tw),
        .or_pc_i  (ctl.or_pc),
        .cma_i    (ctl.cma),
        .ac_i     (ac_i),
        .io_i     (io_i),
        .pc_i     (pc_i),
        .test_i   (test_i),
        .ac_n_o   (ac_n),
        .io_n_o   (io_n)
    );

    opr_flags u_flags (
        .set_i     (ctl.flag_set),
        .sel_i     (ctl.flag_sel),
        .flags_i   (flags_i),
        .flags_n_o (flags_n)
    );

    always_comb begin
        st_d       = st_q;
        st_d.halt  = 1'b0;
        st_d.spare = 1'b0;
        if (st_q.halted) begin
            if (cont_i) st_d.halted = 1'b0;
        end else if (valid_i) begin
            if (ctl.is_spare) begin
                st_d.halt   = 1'b1;
                st_d.spare  = 1'b1;
                st_d.halted = 1'b1;
            end else if (ctl.is_opr) begin
                st_d.ac    = ac_n;
                st_d.io    = io_n;
                st_d.flags = flags_n;
                if (ctl.hlt) begin
                    st_d.halt   = 1'b1;
                    st_d.halted = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ac_o     = st_q.ac;
    assign io_o     = st_q.io;
    assign flags_o  = st_q.flags;
    assign halt_o   = st_q.halt;
    assign spare_o  = st_q.spare;
    assign halted_o = st_q.halted;

    AST_HALT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> !halt_o); // R7

    AST_HALT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |-> halted_o); // R7

    AST_HALTED_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> ($stable(ac_o) && $stable(io_o) && $stable(flags_o) && !halt_o)); // R9

    AST_SPARE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        spare_o |-> ($stable(ac_o) && $stable(io_o) && $stable(flags_o) && halt_o)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(ac_o) && $stable(io_o) && $stable(flags_o))); // R10

endmodule

// File: tb/opr_exec_tb.sv
module opr_exec_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        valid_i;
    logic [17:0] instr_i;
    logic [17:0] ac_i;
    logic [17:0] io_i;
    logic [15:0] pc_i;
    logic [17:0] test_i;
    logic [5:0]  flags_i;
    logic        cont_i;
    logic [17:0] ac_o;
    logic [17:0] io_o;
    logic [5:0]  flags_o;
    logic        halt_o;
    logic        spare_o;
    logic        halted_o;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    opr_exec dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
        .ac_i(ac_i), .io_i(io_i), .pc_i(pc_i), .test_i(test_i),
        .flags_i(flags_i), .cont_i(cont_i), .ac_o(ac_o), .io_o(io_o),
        .flags_o(flags_o), .halt_o(halt_o), .spare_o(spare_o),
        .halted_o(halted_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0o expected=%0o", req, act, exp);
        end
    endtask

    function automatic logic [17:0] model_ac(input logic [11:0] lo, input logic [17:0] a,
                                             input logic [17:0] tw, input logic [15:0] pc);
        logic [17:0] r;
        r = lo[7] ? 18'd0 : a;
        if (lo[10]) r = r | tw;
        if (lo[6])  r = r | {6'd0, pc[11:0]};
        if (lo[9])  r = ~r;
        return r;
    endfunction

    function automatic logic [5:0] model_flags(input logic [11:0] lo, input logic [5:0] f);
        logic [5:0] m;
        if (lo[2:0] == 3'd7)      m = 6'h3f;
        else if (lo[2:0] == 3'd0) m = 6'h00;
        else                      m = 6'(1 << (lo[2:0] - 3'd1));
        return lo[3] ? (f | m) : (f & ~m);
    endfunction

    task automatic release_halt();
        @(negedge clk) cont_i = 1'b1;
        @(negedge clk) cont_i = 1'b0;
        chk("R9 halted cleared by cont", 32'(halted_o), 32'd0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [17:0] pa, pi;
        logic [5:0]  pf;
        rst_n = 1'b0; valid_i = 1'b0; instr_i = '0; ac_i = 18'o777777;
        io_i = 18'o777777; pc_i = '1; test_i = '1; flags_i = '1; cont_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 ac reset", 32'(ac_o), 0);
        chk("R1 io reset", 32'(io_o), 0);
        chk("R1 flags reset", 32'(flags_o), 0);
        chk("R1 strobes reset", 32'({halt_o, spare_o, halted_o}), 0);
        rst_n = 1'b1;

        // R2 R3 R4 R5 R6 R7: exhaustive sweep of the low field
        for (int i = 0; i < 4096; i++) begin
            logic [11:0] lo;
            logic [17:0] a, o, tw;
            logic [15:0] pc;
            logic [5:0]  f;
            lo = 12'(i);
            a  = 18'(i * 18'o1357) ^ 18'o525252;
            o  = ~a ^ 18'(i);
            tw = 18'o314631 ^ 18'(i << 3);
            pc = 16'(i * 7) + 16'hA000;
            f  = 6'(i * 5);
            @(negedge clk);
            valid_i = 1'b1; instr_i = {6'o76 | 6'(i & 1), lo};
            ac_i = a; io_i = o; pc_i = pc; test_i = tw; flags_i = f;
            @(negedge clk);
            valid_i = 1'b0;
            chk("R3/R4/R5 ac", 32'(ac_o), 32'(model_ac(lo, a, tw, pc)));
            chk("R3 io", 32'(io_o), 32'(lo[11] ? 18'd0 : o));
            chk("R6 flags", 32'(flags_o), 32'(model_flags(lo, f)));
            chk("R7 halt strobe", 32'({halt_o, halted_o}), 32'({lo[8], lo[8]}));
            if (lo[8]) begin
                pa = ac_o; pi = io_o; pf = flags_o;
                @(negedge clk);
                chk("R7 strobe one cycle", 32'(halt_o), 0);
                valid_i = 1'b1; instr_i = 18'o764206; ac_i = 18'o123456; io_i = 18'o1;
                @(negedge clk);
                valid_i = 1'b0;
                chk("R9 ignored while halted ac", 32'(ac_o), 32'(pa));
                chk("R9 ignored while halted io/flags", 32'({io_o, flags_o}), 32'({pi, pf}));
                chk("R9 no strobe while halted", 32'({halt_o, halted_o}), 32'b01);
                release_halt();
            end
        end

        // R2 R8: sweep of all major opcodes with an empty low field
        for (int op = 0; op < 64; op++) begin
            logic [4:0] c5;
            logic       sp, opr;
            c5  = 5'(op >> 1);
            sp  = (c5 == 5'd0) || (c5 == 5'd5) || (c5 == 5'd6) || (c5 == 5'd15) || (c5 == 5'd30);
            opr = (c5 == 5'b11111);
            pa = ac_o; pi = io_o; pf = flags_o;
            @(negedge clk);
            valid_i = 1'b1; instr_i = {6'(op), 12'o4217};
            ac_i = 18'(op) ^ 18'o070707; io_i = 18'o606060; flags_i = 6'(op);
            pc_i = 16'h0; test_i = 18'h0;
            @(negedge clk);
            valid_i = 1'b0;
            if (opr) begin
                chk("R2 operate ac", 32'(ac_o), 32'(model_ac(12'o4217, 18'(op) ^ 18'o070707, 0, 0)));
                chk("R2 operate io", 32'(io_o), 0);
            end else begin
                chk("R2/R8 non-operate ac hold", 32'(ac_o), 32'(pa));
                chk("R2/R8 non-operate io/flags hold", 32'({io_o, flags_o}), 32'({pi, pf}));
            end
            chk("R8 spare strobes", 32'({halt_o, spare_o, halted_o}), 32'({sp, sp, sp}));
            if (sp) begin
                @(negedge clk);
                chk("R8 spare strobe one cycle", 32'({halt_o, spare_o}), 0);
                release_halt();
            end
        end

        // R4: PC high bits discarded, lat combination
        @(negedge clk);
        valid_i = 1'b1; instr_i = 18'o760100; ac_i = 18'o0; pc_i = 16'hFABC;
        @(negedge clk);
        valid_i = 1'b0;
        chk("R4 lap low 12 bits", 32'(ac_o), 32'o5274);
        @(negedge clk);
        valid_i = 1'b1; instr_i = 18'o762200; ac_i = 18'o777000; test_i = 18'o123456;
        @(negedge clk);
        valid_i = 1'b0;
        chk("R4 lat loads test word", 32'(ac_o), 32'o123456);

        // R10: valid low holds outputs
        pa = ac_o;
        @(negedge clk);
        instr_i = 18'o761200; ac_i = 18'o1; io_i = 18'o2;
        repeat (3) @(negedge clk);
        chk("R10 idle hold", 32'(ac_o), 32'(pa));

        // R1: reset mid-run clears state
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears ac", 32'(ac_o), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule